// File: doc/BRIEF.md
# Multi-Domain Reset Controller

This block gathers every reset request of a chip and produces three separate active-low reset domains. The power domain reset covers everything except the always-on backup logic. The system domain reset covers the processor and peripherals. The backup domain reset covers only the always-on logic. A fourth output, the debug-port reset, follows the power domain alone, so a debugger keeps its connection across system resets.

Each output goes low asynchronously, as soon as one of its sources appears. It is released synchronously on the system clock, through a synchroniser chain and a hold counter, so every reset pulse has a guaranteed minimum width. The power domain is one of the system domain's sources, so the two release in sequence. A sticky cause register records which system sources fired. It is rebuilt by power reset, survives system resets, and can be cleared by software.

Top module: `reset_domain_ctrl`

## Requirements
- R1: Every reset output is active low. While the power detector input is low, the power, system and debug outputs are all low and the cause register reads 0x001.
- R2: The power reset goes low when the power detector input is low or when the standby-exit input is high. It stays low until the regulator-ready input is high.
- R3: Each reset output is released synchronously. With the defaults (2 synchroniser stages, hold count 16), an output rises at the 18th rising clock edge after its last source goes away, and it is still low after the 17th.
- R4: The system reset goes low while any of these is present: power reset, external pin low, window watchdog, free watchdog, software request, option-loader request, low-voltage detect, crystal clock loss, PLL clock loss, or processor lockup.
- R5: A standby-entry pulse asserts the system reset and sets cause bit 6 only when the standby-keep configuration input is 0. When that input is 1, the pulse has no effect on the outputs or the flags.
- R6: A deep-sleep-entry pulse asserts the system reset and sets cause bit 7 only when the deep-sleep-keep configuration input is 0. When that input is 1, the pulse has no effect on the outputs or the flags.
- R7: The debug reset output follows only the power reset. A system-only reset leaves the debug and backup outputs high.
- R8: The backup reset output is driven only by the backup reset request input. A power reset does not lower it.
- R9: Cause flag positions are: bit 0 power, 1 external pin, 2 window watchdog, 3 free watchdog, 4 software, 5 option loader, 6 standby entry, 7 deep-sleep entry, 8 low voltage, 9 crystal loss, 10 PLL loss, 11 lockup. A flag is set by its source, even by a one-cycle pulse, and it stays set through system resets.
- R10: A power reset clears all cause flags and then sets only bit 0.
- R11: A one-cycle pulse on the flag-clear input clears all flags. A source that fires in the same cycle as the clear still sets its flag.
- R12: When several sources fire in the same cycle, all of their flags are set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_pdr_n_i | input | 1 | Power-on/power-down detector, low while supply is bad |
| ldo_ready_i | input | 1 | Internal regulator ready |
| stby_exit_i | input | 1 | Standby-exit event |
| bkp_rst_n_i | input | 1 | Backup domain reset request, active low |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wwdg_rst_i | input | 1 | Window watchdog reset request |
| fwdg_rst_i | input | 1 | Free watchdog reset request |
| sw_rst_i | input | 1 | Software reset request |
| obl_rst_i | input | 1 | Option-loader reset request |
| stby_enter_i | input | 1 | Standby-entry event |
| cfg_stby_keep_i | input | 1 | 1: standby entry does not reset |
| dpslp_enter_i | input | 1 | Deep-sleep-entry event |
| cfg_dpslp_keep_i | input | 1 | 1: deep-sleep entry does not reset |
| lvd_rst_i | input | 1 | Low-voltage detect |
| hxtal_loss_i | input | 1 | Crystal clock loss |
| pll_loss_i | input | 1 | PLL clock loss |
| lockup_i | input | 1 | Processor lockup |
| flag_clr_i | input | 1 | Clear all cause flags |
| pwr_rst_n_o | output | 1 | Power domain reset |
| sys_rst_n_o | output | 1 | System domain reset |
| dbg_rst_n_o | output | 1 | Debug-port reset |
| bkp_rst_n_o | output | 1 | Backup domain reset |
| cause_o | output | 12 | Sticky reset cause flags |

## Verification
The bench counts the release edge of every domain exactly. A hold counter that is off by one, or a missing synchroniser stage, shows up as an output that rises one edge early or late. Each low-power entry is tried with its keep bit at both values: a design that ignores the bit or inverts its sense either resets when it should not or stays silent. A single-cycle pin pulse, a clear in the same cycle as an event, and three sources firing together expose flags that are lost, or a clear that wins over a new event. System-only and backup-only resets are issued while the other outputs are watched. A design that routes the system reset into the debug or backup outputs, or lets power reset erase the system cause history wrongly, would fail those checks.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the reset domain controller.
// Assumes the cause register bit positions below are fixed software contract.
package rstc_pkg;

    localparam int NUM_CAUSES = 12;

    // Cause bit positions
    localparam int C_PWR   = 0;
    localparam int C_PIN   = 1;
    localparam int C_WWDG  = 2;
    localparam int C_FWDG  = 3;
    localparam int C_SW    = 4;
    localparam int C_OBL   = 5;
    localparam int C_STBY  = 6;
    localparam int C_DPSLP = 7;
    localparam int C_LVD   = 8;
    localparam int C_HXTAL = 9;
    localparam int C_PLL   = 10;
    localparam int C_LOCK  = 11;

    typedef logic [NUM_CAUSES-1:0] cause_vec_t;

    localparam cause_vec_t CAUSE_AFTER_PWR = cause_vec_t'(1) << C_PWR;

endpackage

// File: rtl/rstc_release.sv
`timescale 1ns/1ps
// Module: rstc_release
// Turns a raw active-low reset condition into a clean reset output.
// The output drops asynchronously with raw_n_i. Release goes through a
// SYNC_STAGES flop chain and then a HOLD_CYCLES counter, so the output
// rises SYNC_STAGES + HOLD_CYCLES rising edges after raw_n_i goes high.
// Assumes raw_n_i may change at any time relative to clk_i.
module rstc_release #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk_i,
    input  logic raw_n_i,
    output logic rst_n_o
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          hold_q;
    logic                   out_q;
    logic                   synced;

    // Synchroniser chain, cleared asynchronously by the raw condition
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                // First stage samples a constant one once the raw reset lifts
                always_ff @(posedge clk_i or negedge raw_n_i) begin
                    if (!raw_n_i) sync_q[s] <= 1'b0;
                    else          sync_q[s] <= 1'b1;
                end
            end else begin : g_next
                // Later stages shift the release through
                always_ff @(posedge clk_i or negedge raw_n_i) begin
                    if (!raw_n_i) sync_q[s] <= 1'b0;
                    else          sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    assign synced = sync_q[SYNC_STAGES-1];

    // Hold counter and output flop: release after HOLD_CYCLES synced cycles
    always_ff @(posedge clk_i or negedge raw_n_i) begin
        if (!raw_n_i) begin
            hold_q <= '0;
            out_q  <= 1'b0;
        end else if (synced && !out_q) begin
            if (hold_q == HOLD_LAST) out_q  <= 1'b1;
            else                     hold_q <= hold_q + 1'b1;
        end
    end

    assign rst_n_o = out_q;

endmodule

// File: rtl/rstc_source_merge.sv
`timescale 1ns/1ps
// Module: rstc_source_merge
// Pure combinational merging of reset sources into raw domain conditions
// and into a per-cause event vector. Low-power entries are gated by their
// keep bits (1 = entry does not reset). Bit C_PWR of the event vector is
// always zero: the power flag is produced by the cause register's reset.
// Assumes request inputs are active high except the pin and detector.
module rstc_source_merge
    import rstc_pkg::*;
(
    input  logic       por_pdr_n_i,
    input  logic       ldo_ready_i,
    input  logic       stby_exit_i,
    input  logic       pwr_rst_n_i,
    input  logic       ext_rst_n_i,
    input  logic       wwdg_rst_i,
    input  logic       fwdg_rst_i,
    input  logic       sw_rst_i,
    input  logic       obl_rst_i,
    input  logic       stby_enter_i,
    input  logic       cfg_stby_keep_i,
    input  logic       dpslp_enter_i,
    input  logic       cfg_dpslp_keep_i,
    input  logic       lvd_rst_i,
    input  logic       hxtal_loss_i,
    input  logic       pll_loss_i,
    input  logic       lockup_i,
    output logic       pwr_raw_n_o,
    output logic       sys_raw_n_o,
    output cause_vec_t sys_evt_o
);

    // Power domain: bad supply, not-ready regulator or standby exit
    always_comb begin
        pwr_raw_n_o = por_pdr_n_i & ldo_ready_i & ~stby_exit_i;
    end

    // Per-cause system event vector
    always_comb begin
        sys_evt_o          = '0;
        sys_evt_o[C_PIN]   = ~ext_rst_n_i;
        sys_evt_o[C_WWDG]  = wwdg_rst_i;
        sys_evt_o[C_FWDG]  = fwdg_rst_i;
        sys_evt_o[C_SW]    = sw_rst_i;
        sys_evt_o[C_OBL]   = obl_rst_i;
        sys_evt_o[C_STBY]  = stby_enter_i & ~cfg_stby_keep_i;
        sys_evt_o[C_DPSLP] = dpslp_enter_i & ~cfg_dpslp_keep_i;
        sys_evt_o[C_LVD]   = lvd_rst_i;
        sys_evt_o[C_HXTAL] = hxtal_loss_i;
        sys_evt_o[C_PLL]   = pll_loss_i;
        sys_evt_o[C_LOCK]  = lockup_i;
    end

    // System domain: power reset or any system event
    always_comb begin
        sys_raw_n_o = pwr_rst_n_i & ~(|sys_evt_o);
    end

endmodule

// File: rtl/rstc_cause_log.sv
`timescale 1ns/1ps
// Module: rstc_cause_log
// Sticky reset cause flags. Reset by the power domain to "power only".
// The pin event is synchronised first; all other events are assumed to be
// synchronous to clk_i. An event in the same cycle as a clear still sets.
module rstc_cause_log
    import rstc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       pwr_rst_n_i,
    input  logic       ext_rst_n_i,
    input  cause_vec_t sys_evt_i,
    input  logic       flag_clr_i,
    output cause_vec_t cause_o
);

    logic [SYNC_STAGES-1:0] pin_q;
    cause_vec_t             flags_q;
    cause_vec_t             capture;

    // Pin synchroniser, idles high (pin released)
    always_ff @(posedge clk_i or negedge pwr_rst_n_i) begin
        if (!pwr_rst_n_i) pin_q <= '1;
        else              pin_q <= {pin_q[SYNC_STAGES-2:0], ext_rst_n_i};
    end

    // Events to record this cycle, pin taken from its synchronised copy
    always_comb begin
        capture        = sys_evt_i;
        capture[C_PWR] = 1'b0;
        capture[C_PIN] = ~pin_q[SYNC_STAGES-1];
    end

    // Flag register: clear first, then merge new events
    always_ff @(posedge clk_i or negedge pwr_rst_n_i) begin
        if (!pwr_rst_n_i) flags_q <= CAUSE_AFTER_PWR;
        else              flags_q <= (flag_clr_i ? '0 : flags_q) | capture;
    end

    assign cause_o = flags_q;

endmodule

// File: rtl/reset_domain_ctrl.sv
`timescale 1ns/1ps
// Module: reset_domain_ctrl (top)
// Builds the power, system, debug and backup reset domains and the sticky
// cause register. Power reset feeds the system reset; debug follows power
// only; backup follows its own request only. Outputs assert asynchronously
// and release after SYNC_STAGES + HOLD_CYCLES clock edges.
module reset_domain_ctrl
    import rstc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 16
) (
    input  logic                  clk_i,
    input  logic                  por_pdr_n_i,
    input  logic                  ldo_ready_i,
    input  logic                  stby_exit_i,
    input  logic                  bkp_rst_n_i,
    input  logic                  ext_rst_n_i,
    input  logic                  wwdg_rst_i,
    input  logic                  fwdg_rst_i,
    input  logic                  sw_rst_i,
    input  logic                  obl_rst_i,
    input  logic                  stby_enter_i,
    input  logic                  cfg_stby_keep_i,
    input  logic                  dpslp_enter_i,
    input  logic                  cfg_dpslp_keep_i,
    input  logic                  lvd_rst_i,
    input  logic                  hxtal_loss_i,
    input  logic                  pll_loss_i,
    input  logic                  lockup_i,
    input  logic                  flag_clr_i,
    output logic                  pwr_rst_n_o,
    output logic                  sys_rst_n_o,
    output logic                  dbg_rst_n_o,
    output logic                  bkp_rst_n_o,
    output logic [NUM_CAUSES-1:0] cause_o
);

    logic       pwr_raw_n;
    logic       sys_raw_n;
    logic       pwr_n;
    logic       sys_n;
    logic       bkp_n;
    cause_vec_t sys_evt;

    rstc_source_merge u_merge (
        .por_pdr_n_i      (por_pdr_n_i),
        .ldo_ready_i      (ldo_ready_i),
        .stby_exit_i      (stby_exit_i),
        .pwr_rst_n_i      (pwr_n),
        .ext_rst_n_i      (ext_rst_n_i),
        .wwdg_rst_i       (wwdg_rst_i),
        .fwdg_rst_i       (fwdg_rst_i),
        .sw_rst_i         (sw_rst_i),
        .obl_rst_i        (obl_rst_i),
        .stby_enter_i     (stby_enter_i),
        .cfg_stby_keep_i  (cfg_stby_keep_i),
        .dpslp_enter_i    (dpslp_enter_i),
        .cfg_dpslp_keep_i (cfg_dpslp_keep_i),
        .lvd_rst_i        (lvd_rst_i),
        .hxtal_loss_i     (hxtal_loss_i),
        .pll_loss_i       (pll_loss_i),
        .lockup_i         (lockup_i),
        .pwr_raw_n_o      (pwr_raw_n),
        .sys_raw_n_o      (sys_raw_n),
        .sys_evt_o        (sys_evt)
    );

    rstc_release #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES)) u_pwr_rel (
        .clk_i   (clk_i),
        .raw_n_i (pwr_raw_n),
        .rst_n_o (pwr_n)
    );

    rstc_release #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES)) u_sys_rel (
        .clk_i   (clk_i),
        .raw_n_i (sys_raw_n),
        .rst_n_o (sys_n)
    );

    rstc_release #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES)) u_bkp_rel (
        .clk_i   (clk_i),
        .raw_n_i (bkp_rst_n_i),
        .rst_n_o (bkp_n)
    );

    rstc_cause_log #(.SYNC_STAGES(SYNC_STAGES)) u_cause (
        .clk_i       (clk_i),
        .pwr_rst_n_i (pwr_n),
        .ext_rst_n_i (ext_rst_n_i),
        .sys_evt_i   (sys_evt),
        .flag_clr_i  (flag_clr_i),
        .cause_o     (cause_o)
    );

    assign pwr_rst_n_o = pwr_n;
    assign sys_rst_n_o = sys_n;
    assign dbg_rst_n_o = pwr_n;
    assign bkp_rst_n_o = bkp_n;

endmodule

// File: rtl/reset_domain_ctrl_sva.sv
`timescale 1ns/1ps
// Module: reset_domain_ctrl_sva
// Property checker bound to reset_domain_ctrl. An armed flag keeps every
// property quiet until the first clock edge has been seen.
module reset_domain_ctrl_sva
    import rstc_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input logic             clk_i,
    input logic             por_pdr_n_i,
    input logic             bkp_rst_n_i,
    input logic             ext_rst_n_i,
    input logic             stby_enter_i,
    input logic             cfg_stby_keep_i,
    input logic             flag_clr_i,
    input logic             pwr_rst_n_o,
    input logic             sys_rst_n_o,
    input logic             bkp_rst_n_o,
    input logic [NUM_CAUSES-1:0] cause_o
);

    localparam int LW = $clog2(HOLD_CYCLES + 4);
    localparam logic [LW-1:0] LMAX = LW'(HOLD_CYCLES + 3);

    logic          armed = 1'b0;
    logic [LW-1:0] sys_low_cnt = '0;

    // Arm after the first edge
    always_ff @(posedge clk_i) armed <= 1'b1;

    // Count consecutive low samples of the system reset
    always_ff @(posedge clk_i) begin
        if (sys_rst_n_o)          sys_low_cnt <= '0;
        else if (sys_low_cnt != LMAX) sys_low_cnt <= sys_low_cnt + 1'b1;
    end

    p_por_holds_all_r1: assert property (@(posedge clk_i) disable iff (!armed)
        !por_pdr_n_i |-> (!pwr_rst_n_o && !sys_rst_n_o));

    p_pwr_feeds_sys_r4: assert property (@(posedge clk_i) disable iff (!armed)
        !pwr_rst_n_o |-> !sys_rst_n_o);

    p_pin_asserts_sys_r4: assert property (@(posedge clk_i) disable iff (!armed)
        !ext_rst_n_i |-> !sys_rst_n_o);

    p_min_width_r3: assert property (@(posedge clk_i) disable iff (!armed)
        $rose(sys_rst_n_o) |-> (sys_low_cnt >= LW'(HOLD_CYCLES)));

    p_stby_gate_r5: assert property (@(posedge clk_i) disable iff (!armed)
        (stby_enter_i && !cfg_stby_keep_i) |-> !sys_rst_n_o);

    p_bkp_own_r8: assert property (@(posedge clk_i) disable iff (!armed)
        $rose(bkp_rst_n_o) |-> $past(bkp_rst_n_i));

    p_pwr_flag_only_r10: assert property (@(posedge clk_i) disable iff (!armed)
        !pwr_rst_n_o |-> (cause_o == CAUSE_AFTER_PWR));

    p_sticky_r9: assert property (@(posedge clk_i) disable iff (!armed)
        (pwr_rst_n_o && !flag_clr_i) |=>
            (!pwr_rst_n_o || ((cause_o & $past(cause_o)) == $past(cause_o))));

endmodule

bind reset_domain_ctrl reset_domain_ctrl_sva #(.HOLD_CYCLES(HOLD_CYCLES)) u_sva (
    .clk_i           (clk_i),
    .por_pdr_n_i     (por_pdr_n_i),
    .bkp_rst_n_i     (bkp_rst_n_i),
    .ext_rst_n_i     (ext_rst_n_i),
    .stby_enter_i    (stby_enter_i),
    .cfg_stby_keep_i (cfg_stby_keep_i),
    .flag_clr_i      (flag_clr_i),
    .pwr_rst_n_o     (pwr_rst_n_o),
    .sys_rst_n_o     (sys_rst_n_o),
    .bkp_rst_n_o     (bkp_rst_n_o),
    .cause_o         (cause_o)
);

// File: tb/test_reset_domain_ctrl.sv
`timescale 1ns/1ps
// Directed bench for reset_domain_ctrl: one task per scenario.
module test_reset_domain_ctrl;

    localparam int HOLD = 16;
    localparam int REL  = HOLD + 2;   // edges from source removal to release

    logic clk = 1'b0;
    logic por_n = 1'b0, ldo = 1'b0, sexit = 1'b0, bkp_req_n = 1'b0, pin_n = 1'b1;
    logic wwdg = 1'b0, fwdg = 1'b0, swr = 1'b0, obl = 1'b0;
    logic sent = 1'b0, skeep = 1'b0, dent = 1'b0, dkeep = 1'b0;
    logic lvd = 1'b0, hx = 1'b0, pll = 1'b0, lck = 1'b0, clr = 1'b0;
    logic pwr_n, sys_n, dbg_n, bkp_n;
    logic [11:0] cause;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    reset_domain_ctrl #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD)) i_reset_domain_ctrl (
        .clk_i(clk), .por_pdr_n_i(por_n), .ldo_ready_i(ldo), .stby_exit_i(sexit),
        .bkp_rst_n_i(bkp_req_n), .ext_rst_n_i(pin_n), .wwdg_rst_i(wwdg),
        .fwdg_rst_i(fwdg), .sw_rst_i(swr), .obl_rst_i(obl), .stby_enter_i(sent),
        .cfg_stby_keep_i(skeep), .dpslp_enter_i(dent), .cfg_dpslp_keep_i(dkeep),
        .lvd_rst_i(lvd), .hxtal_loss_i(hx), .pll_loss_i(pll), .lockup_i(lck),
        .flag_clr_i(clr), .pwr_rst_n_o(pwr_n), .sys_rst_n_o(sys_n),
        .dbg_rst_n_o(dbg_n), .bkp_rst_n_o(bkp_n), .cause_o(cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_src(input int idx, input logic v);
        case (idx)
            2:  wwdg = v;
            3:  fwdg = v;
            4:  swr  = v;
            5:  obl  = v;
            8:  lvd  = v;
            9:  hx   = v;
            10: pll  = v;
            11: lck  = v;
            default: ;
        endcase
    endtask

    task automatic clear_flags();
        clr = 1'b1; tick(1); clr = 1'b0; #1;
    endtask

    task automatic t_powerup();
        tick(3); #1;
        chk("R1 pwr low", pwr_n, 0);
        chk("R1 sys low", sys_n, 0);
        chk("R1 dbg low", dbg_n, 0);
        chk("R1 cause", cause, 12'h001);
        bkp_req_n = 1'b1; por_n = 1'b1;
        tick(30); #1;
        chk("R2 held until regulator ready", pwr_n, 0);
        chk("R8 backup released on its own", bkp_n, 1);
        ldo = 1'b1;
        tick(REL - 1); #1;
        chk("R3 pwr still low one edge early", pwr_n, 0);
        tick(1); #1;
        chk("R3 pwr released on time", pwr_n, 1);
        chk("R7 dbg follows pwr", dbg_n, 1);
        chk("R4 sys still held by pwr", sys_n, 0);
        tick(REL - 1); #1;
        chk("R3 sys still low one edge early", sys_n, 0);
        tick(1); #1;
        chk("R3 sys released on time", sys_n, 1);
        chk("R10 only power flag", cause, 12'h001);
    endtask

    task automatic t_single_sources();
        int idx_list[8] = '{2, 3, 4, 5, 8, 9, 10, 11};
        foreach (idx_list[k]) begin
            clear_flags();
            set_src(idx_list[k], 1'b1); #1;
            chk($sformatf("R4 src %0d asserts sys", idx_list[k]), sys_n, 0);
            chk("R7 dbg untouched by sys", dbg_n, 1);
            chk("R7 bkp untouched by sys", bkp_n, 1);
            tick(1); set_src(idx_list[k], 1'b0);
            tick(REL - 1); #1;
            chk("R3 sys hold", sys_n, 0);
            tick(1); #1;
            chk("R3 sys release", sys_n, 1);
            chk($sformatf("R9 flag of src %0d survives", idx_list[k]), cause,
                32'(1) << idx_list[k]);
        end
    endtask

    task automatic t_pin();
        clear_flags();
        pin_n = 1'b0; #1;
        chk("R4 pin asserts sys", sys_n, 0);
        tick(1); pin_n = 1'b1;
        tick(REL); #1;
        chk("R4 pin release", sys_n, 1);
        chk("R9 one-cycle pin pulse recorded", cause, 12'h002);
    endtask

    task automatic t_lowpower();
        clear_flags();
        skeep = 1'b1; sent = 1'b1; #1;
        chk("R5 standby kept: no reset", sys_n, 1);
        tick(1); sent = 1'b0; tick(4); #1;
        chk("R5 standby kept: still no reset", sys_n, 1);
        chk("R5 standby kept: no flag", cause, 12'h000);
        skeep = 1'b0; sent = 1'b1; #1;
        chk("R5 standby resets", sys_n, 0);
        tick(1); sent = 1'b0; tick(REL); #1;
        chk("R5 standby flag bit 6", cause, 12'h040);
        chk("R5 sys back", sys_n, 1);
        clear_flags();
        dkeep = 1'b1; dent = 1'b1; #1;
        chk("R6 deep-sleep kept: no reset", sys_n, 1);
        tick(1); dent = 1'b0; tick(4); #1;
        chk("R6 deep-sleep kept: no flag", cause, 12'h000);
        dkeep = 1'b0; dent = 1'b1; #1;
        chk("R6 deep-sleep resets", sys_n, 0);
        tick(1); dent = 1'b0; tick(REL); #1;
        chk("R6 deep-sleep flag bit 7", cause, 12'h080);
    endtask

    task automatic t_simultaneous();
        clear_flags();
        wwdg = 1'b1; lvd = 1'b1; lck = 1'b1;
        tick(1); wwdg = 1'b0; lvd = 1'b0; lck = 1'b0;
        tick(REL); #1;
        chk("R12 three flags together", cause, 12'h904);
    endtask

    task automatic t_clear();
        chk("R11 flags present before clear", cause, 12'h904);
        clear_flags();
        chk("R11 clear empties flags", cause, 12'h000);
        swr = 1'b1; tick(1); swr = 1'b0;    // set something first
        tick(REL); #1;
        clr = 1'b1; obl = 1'b1; tick(1); clr = 1'b0; obl = 1'b0; #1;
        chk("R11 event wins over same-cycle clear", cause, 12'h020);
        tick(REL); #1;
        chk("R11 sys back after obl", sys_n, 1);
    endtask

    task automatic t_standby_exit();
        sexit = 1'b1; #1;
        chk("R2 standby exit asserts pwr", pwr_n, 0);
        chk("R7 dbg follows pwr", dbg_n, 0);
        chk("R8 bkp not touched by pwr", bkp_n, 1);
        chk("R10 pwr rebuilds cause", cause, 12'h001);
        tick(1); sexit = 1'b0;
        tick(REL); #1;
        chk("R3 pwr back", pwr_n, 1);
        tick(REL); #1;
        chk("R3 sys back after pwr", sys_n, 1);
        chk("R10 cause after power", cause, 12'h001);
    endtask

    task automatic t_backup();
        bkp_req_n = 1'b0; #1;
        chk("R8 bkp asserted", bkp_n, 0);
        chk("R8 pwr untouched", pwr_n, 1);
        chk("R8 sys untouched", sys_n, 1);
        tick(1); bkp_req_n = 1'b1;
        tick(REL - 1); #1;
        chk("R3 bkp hold", bkp_n, 0);
        tick(1); #1;
        chk("R3 bkp release", bkp_n, 1);
        chk("R8 cause unchanged", cause, 12'h001);
        por_n = 1'b0; #1;
        chk("R1 detector low holds pwr", pwr_n, 0);
        chk("R8 bkp stays high on power loss", bkp_n, 1);
        tick(2); por_n = 1'b1;
        tick(2 * REL + 2); #1;
        chk("R1 all back", {pwr_n, sys_n, dbg_n}, 3'b111);
    endtask

    initial begin
        t_powerup();
        t_single_sources();
        t_pin();
        t_lowpower();
        t_simultaneous();
        t_clear();
        t_standby_exit();
        t_backup();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule